// File: doc/BRIEF.md
# UART extension-bit and ID-match detector

This block sits behind an asynchronous serial receiver whose frames carry a ninth, extension bit after eight data bits, the scheme used for multiprocessor addressing on a shared line. Each received frame enters on a valid/ready input. The block optionally inverts the whole frame, checks the extension bit against a selectable level, and optionally compares the data byte with a configured station ID. A qualifying frame sets a sticky detection flag and raises a one-cycle interrupt pulse. The data byte always leaves on a valid/ready output.

The configuration is captured while the block is disabled and frozen while it is enabled. Software therefore sets the mode with the enable low and then raises the enable. Dropping the enable clears the flag and empties the output stage.

Back-pressure works as follows. `in_ready` is high only while the block is enabled and its single output register is empty or being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values.

Top module: `uart_xbit_detect`

## Requirements
- R1: A frame can qualify only when `cfg_len8` = 1 (8 data bits) and `cfg_ext_en` = 1. With either of them 0, no frame sets the flag or pulses the interrupt.
- R2: With `cfg_det_ie` = 0, a frame whose extension bit qualifies leaves `det_flag` unchanged and gives no `det_irq`. With `cfg_det_ie` = 1, the same frame sets the flag and pulses the interrupt.
- R3: The extension bit is `in_frame[8]`. It qualifies when it equals `cfg_det_lvl`.
- R4: `cfg_rx_inv` = 1 inverts all nine frame bits before the level check, the ID compare and the data output.
- R5: With `cfg_id_en` = 1, a frame qualifies only if its extension bit qualifies and its (possibly inverted) data byte `in_frame[7:0]` equals `cfg_id`. On a mismatch, neither the flag nor the interrupt changes.
- R6: The configuration inputs are sampled on every clock edge while `blk_en` = 0 and are held while `blk_en` = 1. Changes made while the block is enabled have no effect.
- R7: `det_flag` stays set until a one-cycle `det_clr`. If a clear and a detection occur in the same cycle, the flag is set.
- R8: `det_irq` is high for exactly the one cycle after the edge that accepts a qualifying frame.
- R9: While `blk_en` = 0, `det_flag` is 0, `out_valid` is 0 and `in_ready` is 0.
- R10: An accepted frame appears on `out_data` with `out_valid` after one edge. The output is held stable while `out_ready` is low, and `in_ready` is low while a full output is not being drained.
- R11: With `cfg_len8` = 0 (7 data bits), bit 7 of `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_en | input | 1 | Block enable; low captures configuration |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_ext_en | input | 1 | Extension-bit operation enable |
| cfg_det_ie | input | 1 | Detection flag/interrupt enable |
| cfg_det_lvl | input | 1 | Qualifying extension-bit level |
| cfg_rx_inv | input | 1 | Invert all received frame bits |
| cfg_id_en | input | 1 | Require the data byte to equal cfg_id |
| cfg_id | input | DATA_W | Station ID for comparison |
| in_valid | input | 1 | Frame valid |
| in_ready | output | 1 | Frame accepted this cycle when high with in_valid |
| in_frame | input | DATA_W+1 | Bit DATA_W is the extension bit, lower bits are data |
| out_valid | output | 1 | Data byte valid |
| out_ready | input | 1 | Downstream accepts data byte |
| out_data | output | DATA_W | Data byte after inversion and length masking |
| det_clr | input | 1 | One-cycle clear of the detection flag |
| det_flag | output | 1 | Sticky detection flag |
| det_irq | output | 1 | One-cycle detection interrupt |

## Verification
The bench builds the block with the default `DATA_W` = 8. At that width the 8-bit length setting and the 7-bit masking are both meaningful. All 64 combinations of the six mode bits fit into one sweep. For every combination, the bench crosses both extension-bit levels with a byte equal to the ID, a byte one bit away from it, and an unrelated byte, so level selection, inversion and ID matching are each seen both hitting and missing. Directed sequences then cover the set-over-clear collision, configuration changes made while enabled, disable clearing, and a stalled output.

// File: rtl/uxd_pkg.sv
package uxd_pkg;
  typedef struct packed {
    logic len8;
    logic ext_en;
    logic det_ie;
    logic det_lvl;
    logic rx_inv;
    logic id_en;
  } uxd_mode_t;
endpackage

// File: rtl/uxd_cfg_hold.sv
module uxd_cfg_hold
  import uxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  uxd_mode_t         mode_in,
  input  logic [DATA_W-1:0] id_in,
  output uxd_mode_t         mode_q,
  output logic [DATA_W-1:0] id_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      id_q   <= '0;
    end else if (!blk_en) begin
      mode_q <= mode_in;
      id_q   <= id_in;
    end
  end

  // R6: shadow frozen across consecutive enabled cycles
  assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && $past(blk_en)) |-> ($stable(mode_q) && $stable(id_q)));
endmodule

// File: rtl/uxd_qualify.sv
module uxd_qualify
  import uxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  uxd_mode_t         mode,
  input  logic [DATA_W-1:0] id,
  input  logic [DATA_W:0]   frame,
  output logic              hit,
  output logic [DATA_W-1:0] data
);
  localparam int FW = DATA_W + 1;

  logic [FW-1:0]     seen;
  logic              xbit_ok;
  logic              id_ok;
  logic              len_ok;
  logic [DATA_W-1:0] len_mask;

  always_comb begin
    seen    = mode.rx_inv ? ~frame : frame;
    xbit_ok = (seen[DATA_W] == mode.det_lvl);
    id_ok   = !mode.id_en || (seen[DATA_W-1:0] == id);
    len_ok  = mode.len8 && mode.ext_en;
    hit     = len_ok && mode.det_ie && xbit_ok && id_ok;
  end

  generate
    if (DATA_W > 1) begin : g_mask
      assign len_mask = mode.len8 ? {DATA_W{1'b1}} : {1'b0, {(DATA_W-1){1'b1}}};
    end else begin : g_nomask
      assign len_mask = '1;
    end
  endgenerate

  assign data = seen[DATA_W-1:0] & len_mask;
endmodule

// File: rtl/uxd_flag.sv
module uxd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_en,
  input  logic accept,
  input  logic hit,
  input  logic clr,
  output logic flag,
  output logic irq
);
  logic set_now;
  assign set_now = blk_en && accept && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= set_now;
      if (!blk_en)      flag <= 1'b0;
      else if (set_now) flag <= 1'b1;
      else if (clr)     flag <= 1'b0;
    end
  end

  // R7: a collision of set and clear leaves the flag set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_now && clr) |=> flag);
  // R8: the interrupt is always accompanied by the flag
  assert_irq_has_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);
  // R9: disable empties the flag
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> !flag);
endmodule

// File: rtl/uxd_out_stage.sv
module uxd_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n || !blk_en) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10: a stalled output holds its value
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && blk_en) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/uart_xbit_detect.sv
module uart_xbit_detect
  import uxd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic              cfg_len8,
  input  logic              cfg_ext_en,
  input  logic              cfg_det_ie,
  input  logic              cfg_det_lvl,
  input  logic              cfg_rx_inv,
  input  logic              cfg_id_en,
  input  logic [DATA_W-1:0] cfg_id,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W:0]   in_frame,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  input  logic              det_clr,
  output logic              det_flag,
  output logic              det_irq
);
  uxd_mode_t         mode_in, mode_q;
  logic [DATA_W-1:0] id_q;
  logic              hit;
  logic [DATA_W-1:0] q_data;
  logic              accept;

  assign mode_in = '{len8: cfg_len8, ext_en: cfg_ext_en, det_ie: cfg_det_ie,
                     det_lvl: cfg_det_lvl, rx_inv: cfg_rx_inv, id_en: cfg_id_en};

  assign in_ready = blk_en && (!out_valid || out_ready);
  assign accept   = in_valid && in_ready;

  uxd_cfg_hold #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
    .mode_in(mode_in), .id_in(cfg_id), .mode_q(mode_q), .id_q(id_q)
  );

  uxd_qualify #(.DATA_W(DATA_W)) u_qual (
    .mode(mode_q), .id(id_q), .frame(in_frame), .hit(hit), .data(q_data)
  );

  uxd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .accept(accept),
    .hit(hit), .clr(det_clr), .flag(det_flag), .irq(det_irq)
  );

  uxd_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .load(accept),
    .load_data(q_data), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R1: without 8-bit length and extension mode no interrupt follows a frame
  assert_gate_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(mode_q.len8 && mode_q.ext_en)) |=> !det_irq);
  // R2: detection disabled means no interrupt
  assert_gate_ie_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_q.det_ie) |=> !det_irq);
  // R9: nothing is taken while disabled
  assert_no_take_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |-> !in_ready);
  // R11: 7-bit mode masks the top data bit
  assert_mask7_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !mode_q.len8 && blk_en) |=> !out_data[DATA_W-1]);
endmodule

// File: tb/uart_xbit_detect_tb.sv
`timescale 1ns/1ps
module uart_xbit_detect_tb;
  localparam int DW = 8;
  localparam logic [DW-1:0] ID = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic blk_en = 1'b0;
  logic cfg_len8 = 0, cfg_ext_en = 0, cfg_det_ie = 0, cfg_det_lvl = 0, cfg_rx_inv = 0, cfg_id_en = 0;
  logic [DW-1:0] cfg_id = ID;
  logic in_valid = 0;
  logic in_ready;
  logic [DW:0] in_frame = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic det_clr = 0;
  logic det_flag, det_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_xbit_detect #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en),
    .cfg_len8(cfg_len8), .cfg_ext_en(cfg_ext_en), .cfg_det_ie(cfg_det_ie),
    .cfg_det_lvl(cfg_det_lvl), .cfg_rx_inv(cfg_rx_inv), .cfg_id_en(cfg_id_en),
    .cfg_id(cfg_id), .in_valid(in_valid), .in_ready(in_ready), .in_frame(in_frame),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .det_clr(det_clr), .det_flag(det_flag), .det_irq(det_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_mode(input logic [5:0] m);
    {cfg_len8, cfg_ext_en, cfg_det_ie, cfg_det_lvl, cfg_rx_inv, cfg_id_en} = m;
  endtask

  // disable, load mode, enable; ends at a negedge with block enabled
  task automatic configure(input logic [5:0] m);
    @(negedge clk);
    blk_en = 1'b0;
    set_mode(m);
    @(negedge clk);
    check("R9 flag low while disabled", det_flag, 0);
    blk_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic send(input logic [DW:0] f);
    in_valid = 1'b1;
    in_frame = f;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic exp_hit(input logic [5:0] m, input logic [DW:0] f);
    logic len8, ext, ie, lvl, inv, iden;
    logic [DW:0] s;
    {len8, ext, ie, lvl, inv, iden} = m;
    s = inv ? ~f : f;
    return len8 & ext & ie & (s[DW] == lvl) & (!iden | (s[DW-1:0] == ID));
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [5:0] m, input logic [DW:0] f);
    logic [DW:0] s;
    s = m[1] ? ~f : f;
    return m[5] ? s[DW-1:0] : {1'b0, s[DW-2:0]};
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] bytes [3];
    repeat (3) @(negedge clk);
    check("R9 reset flag", det_flag, 0);
    check("R8 reset irq", det_irq, 0);
    check("R9 reset in_ready", in_ready, 0);
    check("R9 reset out_valid", out_valid, 0);
    rst_n = 1'b1;

    // sweep: R1 R2 R3 R4 R5 R8 R10 R11
    for (int m = 0; m < 64; m++) begin
      for (int x = 0; x < 2; x++) begin
        for (int b = 0; b < 3; b++) begin
          logic [DW:0] f;
          logic h;
          // inverted ID keeps ID matches reachable in inverting modes
          bytes[0] = m[1] ? ~ID : ID;
          bytes[1] = bytes[0] ^ 8'h10;
          bytes[2] = 8'h3C;
          f = {x[0], bytes[b]};
          h = exp_hit(m[5:0], f);
          configure(m[5:0]);
          check("R10 in_ready when empty", in_ready, 1);
          send(f);
          check("R8 R1 R2 R3 R4 R5 irq", det_irq, h);
          check("R2 R5 R7 flag", det_flag, h);
          check("R10 out_valid", out_valid, 1);
          check("R4 R11 out_data", out_data, exp_data(m[5:0], f));
          @(negedge clk);
          check("R8 irq single cycle", det_irq, 0);
          check("R7 flag sticky", det_flag, h);
        end
      end
    end

    // R7: clear, and set winning over clear
    configure(6'b111100);
    det_clr = 1'b1;
    send({1'b1, 8'h55});
    det_clr = 1'b0;
    check("R7 set wins over clear", det_flag, 1);
    det_clr = 1'b1;
    @(negedge clk);
    det_clr = 1'b0;
    check("R7 clear", det_flag, 0);

    // R6: changes while enabled are ignored (latched: lvl=1, ie=1)
    cfg_det_lvl = 1'b0;
    cfg_det_ie  = 1'b0;
    cfg_rx_inv  = 1'b1;
    send({1'b1, 8'h0F});
    check("R6 latched config irq", det_irq, 1);
    check("R6 latched inversion data", out_data, 8'h0F);

    // R9: disabling clears flag
    @(negedge clk);
    blk_en = 1'b0;
    @(negedge clk);
    check("R9 disable clears flag", det_flag, 0);
    check("R9 disable empties out", out_valid, 0);

    // R10: back-pressure
    configure(6'b100000);
    out_ready = 1'b0;
    send({1'b0, 8'h81});
    check("R10 out valid A", out_valid, 1);
    check("R10 in_ready low when stalled", in_ready, 0);
    in_valid = 1'b1;
    in_frame = {1'b0, 8'h42};
    @(negedge clk);
    check("R10 hold data", out_data, 8'h81);
    @(negedge clk);
    check("R10 hold data 2", out_data, 8'h81);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second frame after drain", out_data, 8'h42);
    @(negedge clk);
    check("R10 drained", out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule